// File: doc/BRIEF.md
# BCD Step Attenuator Controller

This block is the digital control side of a programmable signal attenuator. A host writes an attenuation setting as two and a half BCD digits: a tens-of-dB bit, a whole-dB digit and a tenth-of-dB digit. The host uses a write strobe and two byte enables. An optional range-extension field carries two more bits that pick a coarse 20 dB segment. All writes go into a holding latch. Only a write that carries the low byte commits the held value to the active setting, and a commit must come at least a set number of clock cycles after the previous one.

On each commit the block turns the active BCD setting into a 12-bit linear gain word for a multiplying DAC. The gain is 10^(-N/200), where N is the setting in tenths of a dB (0 to 199). Full scale is 4095. The block multiplies three per-digit Q1.11 factors in turn on one shared multiplier. Codes reserved for muting drive the word to zero. Digits that are not valid BCD are flagged and are also silenced. The strobe and the enables come from an asynchronous host, so they pass through synchronisers before the edge detector.

Top module: `bcd_atten_ctrl`

## Requirements
- R1: In synchronous reset (rst high), dac_word is 0, mute is 1, bad_code is 0, busy and done are 0, atten_code is 11'h00F and seg_sel is 4'b0001.
- R2: A strobe rising edge with only hi_byte_en set loads data_in[10:8] into the holding latch and commits nothing: no done pulse follows and no output changes.
- R3: A strobe rising edge with lo_byte_en set loads data_in[7:0] and schedules a commit of the whole latch. The commit uses bits 10:8 from the latest high-byte load.
- R4: With both enables set, one strobe loads all 11 bits and commits them.
- R5: For a committed valid BCD code (bit 8 = tens, bits 7:4 = units, bits 3:0 = tenths, N = 100·b8 + 10·units + tenths), dac_word lies within 0.6 % + 2 LSB of 4096·10^(-N/200). It never rises as N rises.
- R6: A committed code whose bits 8:0 are zero gives dac_word 4095.
- R7: A code with bits 3:0 = 4'hF and bit 6 = 0 is a mute code, whatever its other bits are. It gives dac_word 0, mute 1 and bad_code 0.
- R8: A code that is not a mute code and has units or tenths above 9 gives dac_word 0, bad_code 1 and mute 0.
- R9: Commits are spaced exactly REFRESH_CYC clock cycles apart, and busy is high after each commit. A low-byte write that arrives while busy is held and applied when the lockout ends.
- R10: If several low-byte writes arrive in one lockout, they produce a single further commit, and that commit carries the last value written.
- R11: seg_sel is one-hot from atten_code[10:9]: 00 gives 0001, 01 gives 0010, 10 gives 0100 and 11 gives 1000.
- R12: done is a one-cycle pulse. dac_word, mute, bad_code and atten_code change only in the cycle in which done is high.
- R13: A strobe with neither enable set changes neither the latch nor the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_strobe | input | 1 | Asynchronous write strobe; its rising edge captures data |
| hi_byte_en | input | 1 | Asynchronous enable for bits 10:8 |
| lo_byte_en | input | 1 | Asynchronous enable for bits 7:0; also requests a commit |
| data_in | input | 11 | Setting: range bits, tens bit, units digit, tenths digit |
| dac_word | output | 12 | Linear gain word for the DAC |
| mute | output | 1 | Active setting is a mute code |
| bad_code | output | 1 | Active setting has a non-BCD digit |
| seg_sel | output | 4 | One-hot coarse segment select |
| atten_code | output | 11 | Active committed setting |
| busy | output | 1 | Refresh lockout running |
| done | output | 1 | One-cycle pulse when a commit lands |

## Verification
The bench sweeps all 200 valid settings and checks both the tolerance band and monotonic order. A wrong factor entry or a bad rounding shift would break one of them somewhere along the sweep. It separates mute codes from invalid ones by writing patterns with bit 6 set, which a loose decoder would silence as a mute. It loads bytes separately to catch a high-byte write that commits early, and it checks that a strobe with no enable leaves the latch alone. It also writes during the lockout to catch dropped or duplicated pending updates and commits that come too early.

// File: rtl/bcd_atten_pkg.sv
`timescale 1ns/1ps
package bcd_atten_pkg;
   localparam int BCD_W     = 9;
   localparam int EXT_W     = 2;
   localparam int CODE_W    = BCD_W + EXT_W;
   localparam int SEG_W     = 1 << EXT_W;
   localparam int FRAC_W    = 11;
   localparam int GAIN_W    = 12;
   localparam int DEC_LAT   = 4;
   localparam logic [BCD_W-1:0] MUTE_CODE = 9'h00F;

   typedef logic [FRAC_W:0] q111_t;
   typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_MUL1, ST_MUL2} gain_st_e;

   // 10^(-k/200) in Q1.11, k = tenths digit
   function automatic q111_t tenth_factor(input logic [3:0] d);
      case (d)
         4'd0: return 12'd2048;
         4'd1: return 12'd2025;
         4'd2: return 12'd2001;
         4'd3: return 12'd1978;
         4'd4: return 12'd1956;
         4'd5: return 12'd1933;
         4'd6: return 12'd1911;
         4'd7: return 12'd1889;
         4'd8: return 12'd1868;
         4'd9: return 12'd1846;
         default: return 12'd0;
      endcase
   endfunction

   // 10^(-k/20) in Q1.11, k = whole-dB digit
   function automatic q111_t unit_factor(input logic [3:0] d);
      case (d)
         4'd0: return 12'd2048;
         4'd1: return 12'd1825;
         4'd2: return 12'd1627;
         4'd3: return 12'd1450;
         4'd4: return 12'd1292;
         4'd5: return 12'd1152;
         4'd6: return 12'd1026;
         4'd7: return 12'd915;
         4'd8: return 12'd815;
         4'd9: return 12'd727;
         default: return 12'd0;
      endcase
   endfunction

   function automatic q111_t tens_factor(input logic d);
      return d ? 12'd648 : 12'd2048;
   endfunction

   function automatic logic is_mute(input logic [BCD_W-1:0] c);
      return (c[3:0] == 4'hF) && !c[6];
   endfunction

   function automatic logic is_bad(input logic [BCD_W-1:0] c);
      return !is_mute(c) && ((c[7:4] > 4'd9) || (c[3:0] > 4'd9));
   endfunction
endpackage

// File: rtl/bcd_atten_sync.sv
`timescale 1ns/1ps
module bcd_atten_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) stg[i] <= '0;
            else     stg[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) stg[i] <= '0;
            else     stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/bcd_atten_loader.sv
`timescale 1ns/1ps
module bcd_atten_loader
   import bcd_atten_pkg::*;
#(
   parameter bit EXT_RANGE   = 1'b1,
   parameter int REFRESH_CYC = 500
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_s,
   input  logic              hi_s,
   input  logic              lo_s,
   input  logic [CODE_W-1:0] data,
   output logic              start,
   output logic [CODE_W-1:0] snap,
   output logic              busy
);
   localparam int CNT_W = (REFRESH_CYC > 2) ? $clog2(REFRESH_CYC) : 1;

   logic             wr_d;
   logic             wr_rise;
   logic [7:0]       low_q;
   logic             tens_q;
   logic [EXT_W-1:0] ext_q;
   logic             pend_q;
   logic [CNT_W-1:0] lock_q;

   assign wr_rise = wr_s && !wr_d;

   always_ff @(posedge clk) begin
      if (rst) wr_d <= 1'b0;
      else     wr_d <= wr_s;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         low_q  <= MUTE_CODE[7:0];
         tens_q <= MUTE_CODE[8];
      end else if (wr_rise) begin
         if (lo_s) low_q  <= data[7:0];
         if (hi_s) tens_q <= data[8];
      end
   end

   if (EXT_RANGE) begin : g_ext
      always_ff @(posedge clk) begin
         if (rst)                  ext_q <= '0;
         else if (wr_rise && hi_s) ext_q <= data[CODE_W-1 -: EXT_W];
      end
   end else begin : g_noext
      assign ext_q = '0;
   end

   assign snap  = {ext_q, tens_q, low_q};
   assign busy  = (lock_q != '0);
   assign start = pend_q && !busy;

   always_ff @(posedge clk) begin
      if (rst)                  pend_q <= 1'b0;
      else if (wr_rise && lo_s) pend_q <= 1'b1;
      else if (start)           pend_q <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (rst)        lock_q <= '0;
      else if (start) lock_q <= CNT_W'(REFRESH_CYC - 1);
      else if (busy)  lock_q <= lock_q - 1'b1;
   end
endmodule

// File: rtl/bcd_atten_gain.sv
`timescale 1ns/1ps
module bcd_atten_gain
   import bcd_atten_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [CODE_W-1:0] code_in,
   output logic [GAIN_W-1:0] gain_o,
   output logic              mute_o,
   output logic              bad_o,
   output logic              done_o,
   output logic [CODE_W-1:0] code_o
);
   localparam int PW  = 2 * (FRAC_W + 1);
   localparam int SH2 = 2 * FRAC_W - GAIN_W;

   gain_st_e          st_q;
   logic [CODE_W-1:0] code_q;
   q111_t             fa_q, fb_q, fc_q, r1_q;
   logic              mute_p, bad_p;
   q111_t             mul_a, mul_b;
   logic [PW-1:0]     mul_p;
   logic [PW:0]       rnd1, rnd2;
   logic [GAIN_W:0]   g_full;
   logic [GAIN_W-1:0] g_sat;

   always_comb begin
      mul_a  = (st_q == ST_MUL2) ? r1_q : fa_q;
      mul_b  = (st_q == ST_MUL2) ? fc_q : fb_q;
      mul_p  = PW'(mul_a) * PW'(mul_b);
      rnd1   = {1'b0, mul_p} + (PW+1)'(2 ** (FRAC_W - 1));
      rnd2   = {1'b0, mul_p} + (PW+1)'(2 ** (SH2 - 1));
      g_full = rnd2[SH2 +: GAIN_W+1];
      g_sat  = g_full[GAIN_W] ? {GAIN_W{1'b1}} : g_full[GAIN_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= ST_IDLE;
         code_q <= '0;
         fa_q   <= '0;
         fb_q   <= '0;
         fc_q   <= '0;
         r1_q   <= '0;
         mute_p <= 1'b1;
         bad_p  <= 1'b0;
         gain_o <= '0;
         mute_o <= 1'b1;
         bad_o  <= 1'b0;
         done_o <= 1'b0;
         code_o <= CODE_W'(MUTE_CODE);
      end else begin
         done_o <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (start) begin
                  code_q <= code_in;
                  st_q   <= ST_LOOK;
               end
            end
            ST_LOOK: begin
               fa_q   <= tens_factor(code_q[8]);
               fb_q   <= unit_factor(code_q[7:4]);
               fc_q   <= tenth_factor(code_q[3:0]);
               mute_p <= is_mute(code_q[BCD_W-1:0]);
               bad_p  <= is_bad(code_q[BCD_W-1:0]);
               st_q   <= ST_MUL1;
            end
            ST_MUL1: begin
               r1_q <= rnd1[FRAC_W +: FRAC_W+1];
               st_q <= ST_MUL2;
            end
            ST_MUL2: begin
               gain_o <= (mute_p || bad_p) ? '0 : g_sat;
               mute_o <= mute_p;
               bad_o  <= bad_p;
               code_o <= code_q;
               done_o <= 1'b1;
               st_q   <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/bcd_atten_ctrl.sv
`timescale 1ns/1ps
module bcd_atten_ctrl
   import bcd_atten_pkg::*;
#(
   parameter bit EXT_RANGE   = 1'b1,
   parameter int REFRESH_CYC = 500,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_strobe,
   input  logic              hi_byte_en,
   input  logic              lo_byte_en,
   input  logic [CODE_W-1:0] data_in,
   output logic [GAIN_W-1:0] dac_word,
   output logic              mute,
   output logic              bad_code,
   output logic [SEG_W-1:0]  seg_sel,
   output logic [CODE_W-1:0] atten_code,
   output logic              busy,
   output logic              done
);
   if (REFRESH_CYC <= DEC_LAT) begin : g_bad_refresh
      $error("REFRESH_CYC must exceed the decode latency");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [2:0]        ctl_s;
   logic              start;
   logic [CODE_W-1:0] snap;

   bcd_atten_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
      .clk (clk),
      .rst (rst),
      .d   ({wr_strobe, hi_byte_en, lo_byte_en}),
      .q   (ctl_s)
   );

   bcd_atten_loader #(.EXT_RANGE(EXT_RANGE), .REFRESH_CYC(REFRESH_CYC)) i_loader (
      .clk   (clk),
      .rst   (rst),
      .wr_s  (ctl_s[2]),
      .hi_s  (ctl_s[1]),
      .lo_s  (ctl_s[0]),
      .data  (data_in),
      .start (start),
      .snap  (snap),
      .busy  (busy)
   );

   bcd_atten_gain i_gain (
      .clk     (clk),
      .rst     (rst),
      .start   (start),
      .code_in (snap),
      .gain_o  (dac_word),
      .mute_o  (mute),
      .bad_o   (bad_code),
      .done_o  (done),
      .code_o  (atten_code)
   );

   if (EXT_RANGE) begin : g_seg
      assign seg_sel = SEG_W'(1) << atten_code[CODE_W-1 -: EXT_W];
   end else begin : g_noseg
      assign seg_sel = SEG_W'(1);
   end
endmodule

// File: rtl/bcd_atten_chk.sv
`timescale 1ns/1ps
module bcd_atten_chk
   import bcd_atten_pkg::*;
(
   input logic              clk,
   input logic              rst,
   input logic              done,
   input logic              busy,
   input logic              mute,
   input logic              bad_code,
   input logic [GAIN_W-1:0] dac_word,
   input logic [SEG_W-1:0]  seg_sel,
   input logic [CODE_W-1:0] atten_code
);
   assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   assert_hold_outputs_R12: assert property (@(posedge clk) disable iff (rst)
      !done |-> ($stable(dac_word) && $stable(mute) && $stable(bad_code) && $stable(atten_code)));

   assert_mute_zero_R7: assert property (@(posedge clk) disable iff (rst)
      (done && mute) |-> (dac_word == '0 && !bad_code));

   assert_bad_zero_R8: assert property (@(posedge clk) disable iff (rst)
      (done && bad_code) |-> (dac_word == '0 && !mute));

   assert_full_scale_R6: assert property (@(posedge clk) disable iff (rst)
      (done && atten_code[BCD_W-1:0] == '0) |-> (dac_word == {GAIN_W{1'b1}}));

   assert_seg_onehot_R11: assert property (@(posedge clk) disable iff (rst)
      $countones(seg_sel) == 1);

   assert_busy_after_commit_R9: assert property (@(posedge clk) disable iff (rst)
      done |-> busy);
endmodule

bind bcd_atten_ctrl bcd_atten_chk i_bcd_atten_chk (
   .clk        (clk),
   .rst        (rst),
   .done       (done),
   .busy       (busy),
   .mute       (mute),
   .bad_code   (bad_code),
   .dac_word   (dac_word),
   .seg_sel    (seg_sel),
   .atten_code (atten_code)
);

// File: tb/test_bcd_atten_ctrl.sv
`timescale 1ns/1ps
module test_bcd_atten_ctrl;
   localparam int REF = 40;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr = 1'b0, hi = 1'b0, lo = 1'b0;
   logic [10:0] data = '0;
   logic [11:0] dac_word;
   logic        mute, bad_code, busy, done;
   logic [3:0]  seg_sel;
   logic [10:0] atten_code;

   int checks = 0, errors = 0;
   int cyc = 0, done_cnt = 0, last_done = 0, prev_done = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   bcd_atten_ctrl #(.EXT_RANGE(1'b1), .REFRESH_CYC(REF), .SYNC_STAGES(2)) i_bcd_atten_ctrl (
      .clk(clk), .rst(rst), .wr_strobe(wr), .hi_byte_en(hi), .lo_byte_en(lo),
      .data_in(data), .dac_word(dac_word), .mute(mute), .bad_code(bad_code),
      .seg_sel(seg_sel), .atten_code(atten_code), .busy(busy), .done(done));

   always @(posedge clk) cyc <= cyc + 1;
   always @(negedge clk) begin
      if (!rst && done) begin
         prev_done = last_done;
         last_done = cyc;
         done_cnt  = done_cnt + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit m_mute(input logic [10:0] c);
      return c[3:0] == 4'hF && !c[6];
   endfunction
   function automatic bit m_bad(input logic [10:0] c);
      return !m_mute(c) && (c[7:4] > 9 || c[3:0] > 9);
   endfunction
   function automatic int ideal(input logic [10:0] c);
      int n = (c[8] ? 100 : 0) + 10 * int'(c[7:4]) + int'(c[3:0]);
      if (n == 0) return 4095;
      return $rtoi(4096.0 * (10.0 ** (-n / 200.0)) + 0.5);
   endfunction
   function automatic bit gain_ok(input logic [10:0] c, input int g);
      real id;
      if (m_mute(c) || m_bad(c)) return g == 0;
      if (c[8:0] == 0) return g == 4095;
      id = real'(ideal(c));
      return (real'(g) <= id * 1.006 + 2.0) && (real'(g) >= id * 0.994 - 2.0);
   endfunction

   task automatic do_write(input logic h, input logic l, input logic [10:0] d);
      @(negedge clk); data = d; hi = h; lo = l;
      repeat (3) @(negedge clk); wr = 1'b1;
      repeat (3) @(negedge clk); wr = 1'b0;
      repeat (4) @(negedge clk); hi = 1'b0; lo = 1'b0;
   endtask

   task automatic wait_done(input int base);
      for (int i = 0; i < 4 * REF + 50; i++) begin
         if (done_cnt > base) break;
         @(negedge clk);
      end
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 4 * REF + 50; i++) begin
         if (!busy) break;
         @(negedge clk);
      end
      repeat (2) @(negedge clk);
   endtask

   task automatic commit_check(input logic [10:0] c, input string req);
      int base = done_cnt;
      do_write(1'b1, 1'b1, c);
      wait_done(base);
      chk(done_cnt == base + 1, {req, " commit"}, done_cnt - base, 1);
      chk(atten_code == c, {req, " code"}, atten_code, c);
      chk(gain_ok(c, dac_word), {req, " gain"}, dac_word,
          (m_mute(c) || m_bad(c)) ? 0 : ideal(c));
      chk(mute == m_mute(c), {req, " mute flag"}, mute, m_mute(c));
      chk(bad_code == m_bad(c), {req, " bad flag"}, bad_code, m_bad(c));
      chk(seg_sel == (4'b1 << c[10:9]), "R11 segment", seg_sel, 4'b1 << c[10:9]);
      wait_idle();
   endtask

   initial begin
      #(8 * 190000);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int base, prev_g, r;
      logic [10:0] c;
      r = $urandom(32'd4242);
      repeat (5) @(negedge clk);
      // R1 reset state
      chk(dac_word == 0, "R1 gain", dac_word, 0);
      chk(mute == 1'b1, "R1 mute", mute, 1);
      chk(bad_code == 1'b0 && busy == 1'b0 && done == 1'b0, "R1 flags", {bad_code, busy, done}, 0);
      chk(atten_code == 11'h00F, "R1 code", atten_code, 11'h00F);
      chk(seg_sel == 4'b0001, "R1 segment", seg_sel, 1);
      rst = 1'b0;
      repeat (3) @(negedge clk);

      // R6 zero code, R4 single write
      commit_check(11'h000, "R6");
      commit_check(11'h199, "R4");

      // R2 high byte only: no commit
      base = done_cnt;
      do_write(1'b1, 1'b0, 11'b101_1111_1111);
      repeat (30) @(negedge clk);
      chk(done_cnt == base, "R2 no commit", done_cnt - base, 0);
      chk(atten_code == 11'h199, "R2 outputs unchanged", atten_code, 11'h199);
      // R3 low byte commits with previously loaded upper bits
      do_write(1'b0, 1'b1, 11'b000_0010_0011);
      wait_done(base);
      chk(atten_code == 11'b101_0010_0011, "R3 merged code", atten_code, 11'b101_0010_0011);
      chk(gain_ok(atten_code, dac_word), "R3 gain", dac_word, ideal(atten_code));
      chk(seg_sel == 4'b0100, "R11 segment 10", seg_sel, 4'b0100);
      wait_idle();

      // R13 strobe without enables
      base = done_cnt;
      do_write(1'b0, 1'b0, 11'h7FF);
      repeat (30) @(negedge clk);
      chk(done_cnt == base && atten_code == 11'b101_0010_0011, "R13 ignored", atten_code, 11'b101_0010_0011);
      do_write(1'b0, 1'b1, 11'h045);
      wait_done(base);
      chk(atten_code == 11'b101_0100_0101, "R13 latch kept", atten_code, 11'b101_0100_0101);
      wait_idle();

      // R7 mute codes, R8 invalid codes
      commit_check(11'h00F, "R7");
      commit_check(11'h1AF, "R7");
      commit_check(11'h68F, "R7");
      commit_check(11'h04F, "R8");
      commit_check(11'h0A3, "R8");
      commit_check(11'h13C, "R8");

      // R9 write during lockout is held, spacing exact
      base = done_cnt;
      do_write(1'b1, 1'b1, 11'h210);
      wait_done(base);
      chk(busy == 1'b1, "R9 busy after commit", busy, 1);
      do_write(1'b1, 1'b1, 11'h387);
      wait_done(base + 1);
      chk(done_cnt == base + 2, "R9 held write applied", done_cnt - base, 2);
      chk(last_done - prev_done == REF, "R9 spacing", last_done - prev_done, REF);
      chk(atten_code == 11'h387, "R9 code", atten_code, 11'h387);
      wait_idle();

      // R10 several writes in one lockout
      base = done_cnt;
      do_write(1'b1, 1'b1, 11'h055);
      wait_done(base);
      do_write(1'b1, 1'b1, 11'h066);
      do_write(1'b1, 1'b1, 11'h077);
      repeat (3 * REF) @(negedge clk);
      chk(done_cnt == base + 2, "R10 single extra commit", done_cnt - base, 2);
      chk(atten_code == 11'h077, "R10 last value", atten_code, 11'h077);
      wait_idle();

      // R5 sweep of all valid codes, R11 segment cycling
      prev_g = 4096;
      for (int n = 0; n < 200; n++) begin
         c = {2'(n % 4), 1'(n / 100), 4'((n / 10) % 10), 4'(n % 10)};
         base = done_cnt;
         do_write(1'b1, 1'b1, c);
         wait_done(base);
         chk(gain_ok(c, dac_word), "R5 gain band", dac_word, ideal(c));
         chk(int'(dac_word) <= prev_g, "R5 monotonic", dac_word, prev_g);
         chk(seg_sel == (4'b1 << c[10:9]), "R11 segment sweep", seg_sel, 4'b1 << c[10:9]);
         prev_g = int'(dac_word);
         wait_idle();
      end

      // random codes
      for (int k = 0; k < 60; k++) begin
         c = 11'($urandom);
         commit_check(c, "R5 random");
      end

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule